// File: doc/BRIEF.md
# Programmable Interval Countdown Timer

A 32-bit down-counting timer that a processor controls through six 16-bit registers. The counter counts down from a programmed period. When it reaches zero it reloads from the period in the same cycle, raises a sticky timeout flag and drives a one-cycle pulse. A maskable interrupt follows the flag. Software picks either single-shot or free-running operation and starts or stops the count through bits in the control register.

Because the bus is only 16 bits wide, software cannot read the live 32-bit count directly. It first writes any value to either snapshot register. That write latches the whole counter at once, and the two halves are then read back at leisure. Writing a period half reloads the counter with the new value and halts it. The interval between zero events is one clock longer than the programmed value.

Top module: `ivtimer`

## Requirements
- R1: After reset the timer is stopped, the status, control and snapshot registers read 0, `irq` and `tick` are low, and the period registers read `PERIOD_INIT`, split into a low half and a high half.
- R2: Registers sit at word addresses 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Addresses 6 and 7 read 0. Status bit 0 is the timeout flag and bit 1 is the running flag. Control bit 0 is the interrupt enable, bit 1 selects continuous mode, bit 2 is start and bit 3 is stop. Start and stop always read back as 0.
- R3: While running, the counter decrements by one per clock. At zero it reloads the period in the same clock, so zero events occur every P+1 clocks for a period value P.
- R4: With continuous mode clear, the first zero event reloads the counter, clears the running flag and stops counting. No later pulse follows.
- R5: `tick` is high for exactly one clock per zero event, in the clock after the counter held zero. For P=0 in continuous mode it stays high.
- R6: A write to either period half updates that half, loads the counter with the combined new period and stops the timer.
- R7: A write of any data to either snapshot address copies the full 32-bit count into both snapshot halves in one clock. The two halves then read back one consistent value.
- R8: A zero event sets the timeout flag, which stays set until any write to the status address clears it.
- R9: `irq` is high exactly when the timeout flag and the interrupt enable are both 1. Clearing either one drops it.
- R10: A control write with start set begins counting. A control write with stop set halts counting, and stop wins when both bits are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| tick | output | 1 | One-clock timeout pulse |

## Verification
The bench sweeps small periods from 0 upward in both modes and measures the distance to each pulse.

- An off-by-one in the reload would make every interval one clock too short or too long.
- A single-shot timer that forgot to stop would produce a second pulse.
- A P=0 timer that failed to reload in place would drop pulses.

The snapshot is taken while the count crosses a 16-bit boundary. A design that latched the halves separately would return a torn value. Further checks confirm that a period write halts a running counter, that stop beats start, and that the interrupt drops on either acknowledge path while the sticky flag survives.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DW = 16;
  localparam int CW = 2 * DW;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_CTRL   = 3'd1;
  localparam logic [2:0] A_PER_LO = 3'd2;
  localparam logic [2:0] A_PER_HI = 3'd3;
  localparam logic [2:0] A_SNP_LO = 3'd4;
  localparam logic [2:0] A_SNP_HI = 3'd5;

  localparam int B_ITO = 0;
  localparam int B_CONT = 1;
  localparam int B_START = 2;
  localparam int B_STOP = 3;

  // Replace one 16-bit half of a 32-bit word.
  function automatic logic [CW-1:0] merge_half(input logic [CW-1:0] old,
                                               input logic [DW-1:0] d,
                                               input logic hi);
    return hi ? {d, old[DW-1:0]} : {old[CW-1:DW], d};
  endfunction

  // Next counter value while running: reload at zero, else decrement.
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c,
                                               input logic [CW-1:0] per);
    return (c == '0) ? per : c - 1'b1;
  endfunction
endpackage

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter logic [CW-1:0] PERIOD_INIT = 32'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] cnt_i,
  input  logic          run_i,
  input  logic          zero_i,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] period_o,
  output logic [CW-1:0] load_val,
  output logic          period_wr,
  output logic          start_wr,
  output logic          stop_wr,
  output logic          cont_o,
  output logic          irq
);
  logic [CW-1:0] per_q, snap_q;
  logic          to_q, ito_q, cont_q;
  logic          ctrl_wr, snap_wr, stat_wr;

  assign stat_wr   = wr_en && (addr == A_STATUS);
  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign period_wr = wr_en && (addr == A_PER_LO || addr == A_PER_HI);
  assign snap_wr   = wr_en && (addr == A_SNP_LO || addr == A_SNP_HI);
  assign start_wr  = ctrl_wr && wdata[B_START];
  assign stop_wr   = ctrl_wr && wdata[B_STOP];
  assign load_val  = merge_half(per_q, wdata, addr == A_PER_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q  <= PERIOD_INIT;
      snap_q <= '0;
      to_q   <= 1'b0;
      ito_q  <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      if (period_wr) per_q <= load_val;
      if (snap_wr) snap_q <= cnt_i;
      if (ctrl_wr) begin
        ito_q  <= wdata[B_ITO];
        cont_q <= wdata[B_CONT];
      end
      if (zero_i) to_q <= 1'b1;
      else if (stat_wr) to_q <= 1'b0;
    end
  end

  assign period_o = per_q;
  assign cont_o   = cont_q;
  assign irq      = to_q && ito_q;

  always_comb begin
    case (addr)
      A_STATUS: rdata = {{(DW-2){1'b0}}, run_i, to_q};
      A_CTRL:   rdata = {{(DW-2){1'b0}}, cont_q, ito_q};
      A_PER_LO: rdata = per_q[DW-1:0];
      A_PER_HI: rdata = per_q[CW-1:DW];
      A_SNP_LO: rdata = snap_q[DW-1:0];
      A_SNP_HI: rdata = snap_q[CW-1:DW];
      default:  rdata = '0;
    endcase
  end

  // R7: a snapshot holds the count seen at the write
  a_r7_snap_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    snap_wr |=> snap_q == $past(cnt_i));
  // R8: a zero event leaves the flag set
  a_r8_to_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    zero_i |=> to_q);
  // R8: flag holds unless a zero event or a status write
  a_r8_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (to_q && !stat_wr) |=> to_q);
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter
  import ivt_pkg::*;
#(
  parameter logic [CW-1:0] PERIOD_INIT = 32'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] period_i,
  input  logic [CW-1:0] load_val,
  input  logic          period_wr,
  input  logic          start_wr,
  input  logic          stop_wr,
  input  logic          cont_i,
  output logic [CW-1:0] cnt_o,
  output logic          run_o,
  output logic          zero_evt,
  output logic          tick
);
  logic [CW-1:0] cnt_q;
  logic          run_q, tick_q;

  assign zero_evt = run_q && (cnt_q == '0) && !period_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= PERIOD_INIT;
      run_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= zero_evt;
      if (period_wr) cnt_q <= load_val;
      else if (run_q) cnt_q <= step_count(cnt_q, period_i);

      if (period_wr) run_q <= 1'b0;
      else if (stop_wr) run_q <= 1'b0;
      else if (start_wr) run_q <= 1'b1;
      else if (zero_evt && !cont_i) run_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
  assign tick  = tick_q;

  // R3: running counter decrements by one
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !period_wr) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R3: zero reloads the period
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> cnt_q == $past(period_i));
  // R4: single-shot halts after zero
  a_r4_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !cont_i && !start_wr) |=> !run_q);
  // R6: period write loads and halts
  a_r6_load_stop: assert property (@(posedge clk) disable iff (!rst_n)
    period_wr |=> (!run_q && cnt_q == $past(load_val)));
  // R10: stop wins over start
  a_r10_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> !run_q);
endmodule

// File: rtl/ivtimer.sv
module ivtimer
  import ivt_pkg::*;
#(
  parameter logic [31:0] PERIOD_INIT = 32'd1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic        tick
);
  logic [CW-1:0] cnt, period, load_val;
  logic          run, zero_evt, period_wr, start_wr, stop_wr, cont;

  ivt_regs #(.PERIOD_INIT(PERIOD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .cnt_i(cnt), .run_i(run), .zero_i(zero_evt), .rdata(rdata),
    .period_o(period), .load_val(load_val), .period_wr(period_wr),
    .start_wr(start_wr), .stop_wr(stop_wr), .cont_o(cont), .irq(irq)
  );

  ivt_counter #(.PERIOD_INIT(PERIOD_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .period_i(period), .load_val(load_val),
    .period_wr(period_wr), .start_wr(start_wr), .stop_wr(stop_wr),
    .cont_i(cont), .cnt_o(cnt), .run_o(run), .zero_evt(zero_evt), .tick(tick)
  );

  // R9: interrupt needs a pending flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(zero_evt) || $past(wr_en && addr == A_CTRL));
endmodule

// File: tb/sim_ivtimer.sv
module sim_ivtimer;
  localparam logic [31:0] PINIT = 32'h0001_86A0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq, tick;
  int          n_chk = 0, n_bad = 0, cyc = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  ivtimer #(.PERIOD_INIT(PINIT)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq(irq), .tick(tick));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  // negedges until tick seen (0 if none within lim)
  task automatic wait_tick(input int lim, output int idx);
    idx = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (tick && idx == 0) begin idx = i; break; end
    end
  endtask

  task automatic set_period(input logic [31:0] p);
    wr(3'd3, p[31:16]);
    wr(3'd2, p[15:0]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] v, v2;
    int idx, idx2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 status", v, 0);
    rd(3'd1, v); check("R1 control", v, 0);
    rd(3'd2, v); check("R1 period lo", v, PINIT[15:0]);
    rd(3'd3, v); check("R1 period hi", v, PINIT[31:16]);
    rd(3'd4, v); check("R1 snap lo", v, 0);
    rd(3'd5, v); check("R1 snap hi", v, 0);
    check("R1 irq/tick", {irq, tick}, 0);
    // R2 unused addresses
    rd(3'd6, v); check("R2 addr6", v, 0);
    rd(3'd7, v); check("R2 addr7", v, 0);

    // R3/R4/R5 sweep over periods and both modes
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p <= 5; p++) begin
        set_period(p);
        wr(3'd0, 16'h0);
        wr(3'd1, 16'h0004 | 16'(m << 1));
        wait_tick(20, idx);
        check($sformatf("R3 first zero m=%0d P=%0d", m, p), idx, p + 1);
        if (m == 1) begin
          if (p > 0) begin
            @(negedge clk);
            check($sformatf("R5 width P=%0d", p), tick, 0);
            wait_tick(20, idx2);
            check($sformatf("R3 interval P=%0d", p), idx2 + 1, p + 1);
          end else begin
            @(negedge clk);
            check("R5 P=0 continuous", tick, 1);
          end
          rd(3'd0, v); check("R3 running", v[1], 1);
        end else begin
          rd(3'd0, v); check($sformatf("R4 halted P=%0d", p), v, 16'h0001);
          wait_tick(2 * p + 6, idx2);
          check($sformatf("R4 no second tick P=%0d", p), idx2, 0);
          // reloaded counter visible through snapshot
          wr(3'd4, 16'hABCD);
          rd(3'd4, v); check("R4 reloaded lo", v, p);
        end
      end
    end

    // R7 coherent snapshot across the 16-bit boundary
    set_period(32'h0001_0002);
    wr(3'd1, 16'h0006);
    @(negedge clk); @(negedge clk);
    wr(3'd5, 16'h1234);
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R7 snap lo", v, 16'hFFFF);
    rd(3'd5, v); check("R7 snap hi", v, 16'h0000);

    // R6 period write halts a running counter and loads it
    wr(3'd2, 16'h0010);
    rd(3'd0, v); check("R6 run cleared", v[1], 0);
    repeat (4) @(negedge clk);
    wr(3'd4, 16'h0);
    rd(3'd4, v); rd(3'd5, v2);
    check("R6 counter loaded", {v2, v}, 32'h0001_0010);
    rd(3'd2, v); check("R6 period lo", v, 16'h0010);

    // R10 stop bit, stop wins, start/stop read as 0
    set_period(32'd200);
    wr(3'd1, 16'h0006);
    repeat (10) @(negedge clk);
    wr(3'd1, 16'h000A);
    wr(3'd4, 16'h0); rd(3'd4, v);
    repeat (6) @(negedge clk);
    wr(3'd4, 16'h0); rd(3'd4, v2);
    check("R10 stop freezes", v2, v);
    rd(3'd0, v); check("R10 stopped", v[1], 0);
    wr(3'd1, 16'h000F);
    rd(3'd0, v); check("R10 stop wins", v[1], 0);
    rd(3'd1, v); check("R2 control readback", v, 16'h0003);

    // R8/R9 interrupt and acknowledge
    set_period(32'd3);
    wr(3'd0, 16'h0);
    wr(3'd1, 16'h0005);
    wait_tick(20, idx);
    @(negedge clk);
    check("R9 irq raised", irq, 1);
    repeat (10) @(negedge clk);
    rd(3'd0, v); check("R8 flag sticky", v[0], 1);
    wr(3'd0, 16'h0);
    check("R9 ack by status", irq, 0);
    rd(3'd0, v); check("R8 status clears", v[0], 0);
    wr(3'd1, 16'h0005);
    wait_tick(20, idx);
    @(negedge clk);
    check("R9 irq again", irq, 1);
    wr(3'd1, 16'h0000);
    check("R9 ack by enable", irq, 0);
    rd(3'd0, v); check("R8 flag kept", v[0], 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule